// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the column addresses that a synchronous DRAM burst visits, one address per clock. A requester pulses `start` with a start column and the four low bits of the mode word. Bits 2..0 of that word give the burst length and bit 3 gives the beat ordering. The block then runs the burst, marks the final beat of a fixed-length burst, and returns to idle. A memory model can use it to pick the storage word for each beat. A controller can use it to know in which order returned data arrives.

Two orderings are supported. The sequential ordering counts upward and wraps inside the aligned block of the burst length. The interleaved ordering XORs the beat number into the low column bits. A page-length burst counts through the whole page, wrapping at its end, and ends only when `stop` is asserted. That length is legal only with the sequential ordering. Reserved encodings raise a one-cycle error pulse and no beats are produced.

The controller is a four-state machine. IDLE waits for `start`. BURST runs a fixed-length burst. PAGE runs a page-length burst. FAULT marks a rejected request. The transitions are:
- IDLE to BURST on a legal fixed-length request.
- IDLE to PAGE on a legal page-length request.
- IDLE to FAULT on a reserved request.
- BURST to IDLE on the final beat or on `stop`.
- PAGE to IDLE on `stop`.
- FAULT to IDLE after one cycle.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid`, `last_beat` and `cfg_err` are low.
- R2: Length code `mode_cfg[2:0]` selects the beat count: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a page-length burst. A fixed burst produces exactly that many beats.
- R3: `mode_cfg[3]` selects the ordering: 0 is sequential and 1 is interleaved.
- R4: In sequential order, beat i has column bits above log2(BL) equal to the start column. Its low log2(BL) bits are the start column's low bits plus i, modulo BL.
- R5: In interleaved order, beat i is the start column with its low log2(BL) bits XORed with i. The upper bits are unchanged.
- R6: When `start` is sampled high in IDLE, the first beat is presented in the following cycle. After that there is one beat per cycle. `last_beat` is high only on the final beat of a fixed burst, and `beat_valid` is low in the cycle after it.
- R7: A page-length burst presents the start column plus i, modulo 2^COL_W, on beat i. It never raises `last_beat` and continues until `stop` is sampled.
- R8: Length codes 100, 101 and 110, and code 111 with the interleaved ordering, are reserved. For these, `cfg_err` is high for exactly the one cycle after the start edge and no beat is presented.
- R9: `start` sampled while a burst is running is ignored, and the running burst's column sequence is unchanged.
- R10: While a burst runs, the beat during which `stop` is high is its final beat, and `beat_valid` is low in the next cycle. `stop` has no effect in IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request, sampled in IDLE |
| start_col | input | COL_W | Start column of the burst |
| mode_cfg | input | 4 | Bit 3 ordering, bits 2..0 length code |
| stop | input | 1 | Ends a running burst after the current beat |
| beat_valid | output | 1 | A beat column is presented this cycle |
| col_addr | output | COL_W | Column of the current beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | One-cycle pulse on a reserved request |

## Verification
The bench builds the block with the default COL_W of 8, a 256-column page. At this width every start column can be swept for every legal length and ordering. Page-length bursts are run past the end of the page to reach the wrap from 255 to 0. Random bursts add early stops and mid-burst start requests, and every reserved encoding is exercised in both orderings.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2,
        ST_FAULT = 2'd3
    } bcs_state_e;

    typedef struct packed {
        logic       legal;
        logic       full;
        logic       ilv;
        logic [1:0] bl_log;
    } bcs_mode_t;

    // Decode of the four low mode bits: [3] ordering, [2:0] length code
    function automatic bcs_mode_t bcs_decode(input logic [3:0] cfg);
        bcs_mode_t m;
        m.ilv    = cfg[3];
        m.full   = 1'b0;
        m.legal  = 1'b1;
        m.bl_log = 2'd0;
        unique case (cfg[2:0])
            3'b000: m.bl_log = 2'd0;
            3'b001: m.bl_log = 2'd1;
            3'b010: m.bl_log = 2'd2;
            3'b011: m.bl_log = 2'd3;
            3'b111: begin
                m.full  = ~cfg[3];
                m.legal = ~cfg[3];
            end
            default: m.legal = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
    import bcs_pkg::*;
(
    input  logic [3:0] mode_cfg,
    output bcs_mode_t  mode
);

    always_comb begin
        mode = bcs_decode(mode_cfg);
    end

    always_comb begin
        if (mode.full) begin
            AST_FULL_SEQ_ONLY: assert (!mode.ilv); // R7
        end
    end

endmodule

// File: rtl/bcs_mask_gen.sv
module bcs_mask_gen #(
    parameter int COL_W = 8
) (
    input  logic             full,
    input  logic [1:0]       bl_log,
    output logic [COL_W-1:0] mask
);

    localparam int FIXED_BITS = 3;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        if (b < FIXED_BITS) begin : g_low
            assign mask[b] = full | (32'(bl_log) > b);
        end else begin : g_high
            assign mask[b] = full;
        end
    end

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    always_comb begin
        seq_low = (base + idx) & mask;
        ilv_low = (base ^ idx) & mask;
        col     = (base & ~mask) | (ilv ? ilv_low : seq_low);
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [3:0]       mode_cfg,
    input  logic             stop,
    output logic             beat_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             last_beat,
    output logic             cfg_err
);

    localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

    bcs_state_e       state_q, state_d;
    bcs_mode_t        req_mode;
    logic [COL_W-1:0] req_mask;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             full_q;
    logic             last_hit;
    logic [COL_W-1:0] beat_col;

    bcs_mode_decode u_dec (
        .mode_cfg (mode_cfg),
        .mode     (req_mode)
    );

    bcs_mask_gen #(.COL_W(COL_W)) u_mask (
        .full   (req_mode.full),
        .bl_log (req_mode.bl_log),
        .mask   (req_mask)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_col (
        .base (base_q),
        .idx  (idx_q),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (beat_col)
    );

    assign last_hit = !full_q && (idx_q == mask_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!req_mode.legal)    state_d = ST_FAULT;
                    else if (req_mode.full) state_d = ST_PAGE;
                    else                    state_d = ST_BURST;
                end
            end
            ST_BURST: if (stop || last_hit) state_d = ST_IDLE;
            ST_PAGE:  if (stop) state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start && req_mode.legal) begin
                base_q <= start_col;
                idx_q  <= '0;
                mask_q <= req_mask;
                ilv_q  <= req_mode.ilv;
                full_q <= req_mode.full;
            end
        end else if (state_q == ST_BURST || state_q == ST_PAGE) begin
            idx_q <= idx_q + COL_ONE;
        end
    end

    // Outputs
    always_comb begin
        beat_valid = 1'b0;
        last_beat  = 1'b0;
        cfg_err    = 1'b0;
        col_addr   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BURST: begin
                beat_valid = 1'b1;
                col_addr   = beat_col;
                last_beat  = last_hit;
            end
            ST_PAGE: begin
                beat_valid = 1'b1;
                col_addr   = beat_col;
            end
            ST_FAULT: cfg_err = 1'b1;
            default: ;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !beat_valid && !cfg_err); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !ilv_q && !last_beat && !stop
        |=> beat_valid && (((col_addr - $past(col_addr)) & mask_q) == COL_ONE)); // R4
    AST_HIGH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !last_beat && !stop
        |=> ((col_addr & ~mask_q) == ($past(col_addr) & ~mask_q))); // R5
    AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && last_beat |=> !beat_valid); // R6
    AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !beat_valid); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !cfg_err && !beat_valid); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !last_beat && !stop |=> $stable(base_q)); // R9
    AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && stop |=> !beat_valid); // R10

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;
    localparam int PAGE       = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [3:0]       mode_cfg = '0;
    logic             stop = 1'b0;
    logic             beat_valid;
    logic [COL_W-1:0] col_addr;
    logic             last_beat;
    logic             cfg_err;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .mode_cfg   (mode_cfg),
        .stop       (stop),
        .beat_valid (beat_valid),
        .col_addr   (col_addr),
        .last_beat  (last_beat),
        .cfg_err    (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Beat count for a length code; 0 marks reserved, PAGE marks page length
    function automatic int ref_len(input int code, input bit ilv);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return ilv ? 0 : PAGE;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_col(input int b, input int bl, input bit ilv, input int i);
        int m;
        m = bl - 1;
        if (ilv) return (b & ~m & (PAGE-1)) | ((b ^ i) & m);
        return (b & ~m & (PAGE-1)) | ((b + i) & m);
    endfunction

    // stop_at < 0: no stop; poke_at >= 0: start pulse with another column at that beat
    task automatic do_burst(input int col, input int code, input bit ilv,
                            input int stop_at, input int poke_at);
        int bl;
        int nb;
        bit full;
        bl = ref_len(code, ilv);
        full = (bl == PAGE);
        @(negedge clk);
        start = 1'b1;
        start_col = COL_W'(col);
        mode_cfg = {ilv, 3'(code)};
        @(negedge clk);
        start = 1'b0;
        start_col = COL_W'($urandom);
        mode_cfg = 4'($urandom);
        if (bl == 0) begin
            chk(cfg_err == 1'b1, "R8 err pulse", int'(cfg_err), 1);
            chk(beat_valid == 1'b0, "R8 no beat", int'(beat_valid), 0);
            @(negedge clk);
            chk(cfg_err == 1'b0, "R8 err one cycle", int'(cfg_err), 0);
            chk(beat_valid == 1'b0, "R8 no beat after", int'(beat_valid), 0);
            return;
        end
        if (full) nb = stop_at + 1;
        else if (stop_at >= 0 && stop_at < bl) nb = stop_at + 1;
        else nb = bl;
        for (int i = 0; i < nb; i++) begin
            if (i > 0) @(negedge clk);
            start = 1'b0;
            chk(beat_valid == 1'b1, "R6 beat valid", int'(beat_valid), 1);
            chk(int'(col_addr) == ref_col(col, bl, ilv, i),
                full ? "R7 page col" : (ilv ? "R5 ilv col" : "R4 seq col"),
                int'(col_addr), ref_col(col, bl, ilv, i));
            chk(last_beat == (!full && i == bl-1), "R6 last flag R2",
                int'(last_beat), int'(!full && i == bl-1));
            if (i == stop_at) stop = 1'b1;
            if (i == poke_at && i < nb-1) begin
                start = 1'b1;
                start_col = COL_W'(col + 3);
                mode_cfg = 4'b0111;
            end
        end
        @(negedge clk);
        stop = 1'b0;
        start = 1'b0;
        chk(beat_valid == 1'b0, stop_at >= 0 ? "R10 ended" : "R2 ended",
            int'(beat_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(beat_valid == 1'b0, "R1 valid", int'(beat_valid), 0);
        chk(last_beat == 1'b0, "R1 last", int'(last_beat), 0);
        chk(cfg_err == 1'b0, "R1 err", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_valid == 1'b0, "R1 idle after reset", int'(beat_valid), 0);

        // R10: stop in idle does nothing
        stop = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(beat_valid == 1'b0 && cfg_err == 1'b0, "R10 idle stop",
                int'(beat_valid), 0);
        end
        stop = 1'b0;

        // R2 R3 R4 R5: every start column, every fixed length, both orders
        for (int c = 0; c < PAGE; c++)
            for (int code = 0; code < 4; code++)
                for (int t = 0; t < 2; t++)
                    do_burst(c, code, t[0], -1, -1);

        // R7: page bursts across the wrap
        do_burst(0, 7, 1'b0, 260, -1);
        do_burst(255, 7, 1'b0, 3, -1);
        do_burst(250, 7, 1'b0, 9, -1);
        do_burst(129, 7, 1'b0, 0, -1);

        // R8: reserved encodings
        for (int code = 4; code < 8; code++)
            for (int t = 0; t < 2; t++)
                if (ref_len(code, t[0]) == 0) do_burst(code * 17, code, t[0], -1, -1);

        // R9: start while running is ignored
        do_burst(13, 3, 1'b0, -1, 2);
        do_burst(13, 3, 1'b1, -1, 0);
        do_burst(40, 7, 1'b0, 20, 5);

        // R10: early stop of fixed bursts
        do_burst(6, 3, 1'b0, 2, -1);
        do_burst(6, 3, 1'b1, 0, -1);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int code;
            int sa;
            int pk;
            bit t;
            code = int'($urandom % 8);
            t = 1'($urandom);
            sa = (($urandom % 4) == 0) ? int'($urandom % 8) : -1;
            if (code == 7) sa = int'($urandom % 300);
            pk = (($urandom % 5) == 0) ? int'($urandom % 4) : -1;
            do_burst(int'($urandom % PAGE), code, t, sa, pk);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule